// File: doc/BRIEF.md
# Message Region Address Generator

This block steps through the sample addresses of a 64K-sample store that is split into four equal message regions of 16K samples each. The store is built from two 32K banks. A load command moves the counter to the first address of the region named by a 2-bit message number. Each increment command then moves it forward by one sample. A done flag tells the sequencer that the address has left the selected region, which marks the end of that message.

The block also produces the per-bank active-low chip selects. It forms them from the top address bit and a shared active-low select. The shared active-low write enable goes to both banks unchanged, and each bank is given the low 15 address bits.

Top module: `msg_addr_gen`

## Requirements
- R1: After reset is asserted (active-low `rst_n`), `addr` is 0x0000.
- R2: When `load` is high at a rising clock edge, `addr` becomes {msg_num, 14'b0} after that edge.
- R3: When `incr` is high and `load` is low at a rising clock edge, `addr` becomes addr+1 modulo 2^16 after that edge.
- R4: When both `load` and `incr` are high, the load wins and no increment is applied.
- R5: When neither `load` nor `incr` is high, `addr` holds its value.
- R6: `done` is high, combinationally, exactly when addr[15:14] differs from `msg_num`. It therefore rises in the same cycle that an increment steps past the last address of the region.
- R7: `bank0_cs_n` is low exactly when `cs_n` is low and addr[15] is 0. `bank1_cs_n` is low exactly when `cs_n` is low and addr[15] is 1. The two are never low together.
- R8: `bank_addr` equals addr[14:0].
- R9: `bank_we_n` equals `we_n` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Preset the counter to the region start |
| incr | input | 1 | Advance the counter by one |
| msg_num | input | 2 | Current message number |
| cs_n | input | 1 | Shared active-low memory select |
| we_n | input | 1 | Shared active-low write enable |
| addr | output | 16 | Full sample address |
| done | output | 1 | Address lies outside the selected region |
| bank_addr | output | 15 | Address given to each bank |
| bank0_cs_n | output | 1 | Active-low select, lower bank |
| bank1_cs_n | output | 1 | Active-low select, upper bank |
| bank_we_n | output | 1 | Active-low write enable to both banks |

## Verification
The address is registered, so the effect of `load` or `incr` appears one clock edge after the command is sampled. The bench drives commands on the falling edge and reads `addr` at the next falling edge. `done`, the bank selects, `bank_addr` and `bank_we_n` are combinational from the current address and inputs. They are checked in the same half-cycle in which their inputs are settled, which includes the cycle that crosses a region boundary. The pass-through outputs are also checked right after `cs_n`, `we_n` or `msg_num` change, with no clock edge in between.

// File: rtl/msg_addr_pkg.sv
package msg_addr_pkg;
    localparam int ADDR_W   = 16;
    localparam int REGION_W = 2;
    localparam int BANK_W   = ADDR_W - 1;
    localparam int OFFS_W   = ADDR_W - REGION_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_state_t;
endpackage

// File: rtl/region_counter.sv
module region_counter
    import msg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                incr,
    input  logic [REGION_W-1:0] msg_num,
    output logic [ADDR_W-1:0]   addr
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.addr = {msg_num, {OFFS_W{1'b0}}};
        else if (incr)
            st_d.addr = st_q.addr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;

    assert_reset_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> st_q.addr == '0);
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) && $past(rst_n) |-> st_q.addr == {$past(msg_num), {OFFS_W{1'b0}}});
    assert_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(incr) && !$past(load) && $past(rst_n) |-> st_q.addr == $past(st_q.addr) + 1'b1);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(incr) && !$past(load) && $past(rst_n) |-> $stable(st_q.addr));
endmodule

// File: rtl/region_exit.sv
module region_exit
    import msg_addr_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REGION_W-1:0] msg_num,
    output logic                done
);
    logic [REGION_W-1:0] diff;

    always_comb begin
        diff = addr[ADDR_W-1 -: REGION_W] ^ msg_num;
        done = |diff;
    end
endmodule

// File: rtl/bank_select.sv
module bank_select
    import msg_addr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    output logic [BANK_W-1:0] bank_addr,
    output logic              bank0_cs_n,
    output logic              bank1_cs_n,
    output logic              bank_we_n
);
    always_comb begin
        bank_addr  = addr[BANK_W-1:0];
        bank0_cs_n = cs_n | addr[ADDR_W-1];
        bank1_cs_n = cs_n | ~addr[ADDR_W-1];
        bank_we_n  = we_n;
    end

    always_comb begin
        assert_onehot_cs_R7: assert (!(bank0_cs_n === 1'b0 && bank1_cs_n === 1'b0));
    end
endmodule

// File: rtl/msg_addr_gen.sv
module msg_addr_gen
    import msg_addr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                incr,
    input  logic [REGION_W-1:0] msg_num,
    input  logic                cs_n,
    input  logic                we_n,
    output logic [ADDR_W-1:0]   addr,
    output logic                done,
    output logic [BANK_W-1:0]   bank_addr,
    output logic                bank0_cs_n,
    output logic                bank1_cs_n,
    output logic                bank_we_n
);
    region_counter u_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .incr(incr),
        .msg_num(msg_num), .addr(addr)
    );

    region_exit u_exit (
        .addr(addr), .msg_num(msg_num), .done(done)
    );

    bank_select u_bank (
        .addr(addr), .cs_n(cs_n), .we_n(we_n), .bank_addr(bank_addr),
        .bank0_cs_n(bank0_cs_n), .bank1_cs_n(bank1_cs_n), .bank_we_n(bank_we_n)
    );

    assert_load_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) && $past(incr) && $past(rst_n) |-> addr[OFFS_W-1:0] == '0);
    assert_done_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) && $past(rst_n) && $stable(msg_num) |-> !done);
    assert_bank_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (bank0_cs_n != bank1_cs_n));
endmodule

// File: tb/tb_msg_addr_gen.sv
module tb_msg_addr_gen;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        load = 0, incr = 0, cs_n = 1, we_n = 1;
    logic [1:0]  msg_num = 0;
    logic [15:0] addr;
    logic        done;
    logic [14:0] bank_addr;
    logic        bank0_cs_n, bank1_cs_n, bank_we_n;
    int          tests = 0, fails = 0;

    always #5 clk = ~clk;

    msg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .load(load), .incr(incr), .msg_num(msg_num),
        .cs_n(cs_n), .we_n(we_n), .addr(addr), .done(done), .bank_addr(bank_addr),
        .bank0_cs_n(bank0_cs_n), .bank1_cs_n(bank1_cs_n), .bank_we_n(bank_we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply one command at a falling edge and land on the next falling edge.
    task automatic step(input logic l, input logic i);
        load = l; incr = i;
        @(negedge clk);
        load = 0; incr = 0;
    endtask

    task automatic t_reset;
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R1 reset addr", addr, 16'h0000);
        rst_n = 1;
    endtask

    task automatic t_load_all;
        for (int m = 0; m < 4; m++) begin
            msg_num = m[1:0];
            step(1, 0);
            chk("R2 load", addr, {m[1:0], 14'h0});
            chk("R6 done low in region", done, 0);
            chk("R8 bank addr", bank_addr, 15'(addr));
        end
    endtask

    task automatic t_incr_hold;
        logic [15:0] e;
        msg_num = 2'd1; step(1, 0);
        e = 16'h4000;
        for (int k = 0; k < 5; k++) begin
            step(0, 1); e++;
            chk("R3 incr", addr, e);
        end
        step(0, 0); step(0, 0);
        chk("R5 hold", addr, e);
    endtask

    task automatic t_priority;
        msg_num = 2'd2; step(1, 0);
        step(0, 1); step(0, 1);
        step(1, 1);
        chk("R4 load over incr", addr, 16'h8000);
    endtask

    task automatic t_boundary;
        msg_num = 2'd0; step(1, 0);
        for (int k = 0; k < 16383; k++) step(0, 1);
        chk("R3 last in region", addr, 16'h3FFF);
        chk("R6 done low at last", done, 0);
        step(0, 1);
        chk("R3 first beyond", addr, 16'h4000);
        chk("R6 done at crossing", done, 1);
        msg_num = 2'd1; #1;
        chk("R6 done follows msg", done, 0);
        msg_num = 2'd3; #1;
        chk("R6 done both bits", done, 1);
    endtask

    task automatic t_wrap;
        msg_num = 2'd3; step(1, 0);
        for (int k = 0; k < 16384; k++) step(0, 1);
        chk("R3 wrap", addr, 16'h0000);
        chk("R6 done after wrap", done, 1);
    endtask

    task automatic t_banks;
        msg_num = 2'd1; step(1, 0);
        cs_n = 1; #1;
        chk("R7 idle b0", bank0_cs_n, 1); chk("R7 idle b1", bank1_cs_n, 1);
        cs_n = 0; #1;
        chk("R7 low half b0", bank0_cs_n, 0); chk("R7 low half b1", bank1_cs_n, 1);
        msg_num = 2'd2; step(1, 0);
        chk("R7 high half b0", bank0_cs_n, 1); chk("R7 high half b1", bank1_cs_n, 0);
        chk("R8 bank addr high", bank_addr, 15'h0000);
        step(0, 1);
        chk("R8 bank addr low bits", bank_addr, 15'h0001);
        cs_n = 1; we_n = 0; #1;
        chk("R9 we low", bank_we_n, 0);
        we_n = 1; #1;
        chk("R9 we high", bank_we_n, 1);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_load_all();
                t_incr_hold();
                t_priority();
                t_boundary();
                t_wrap();
                t_banks();
            end
            begin
                repeat (150000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule